// File: doc/BRIEF.md
# Linked Work-Descriptor Channel Sequencer

This block runs one channel of a descriptor-driven engine. Software places work descriptors in memory, each eight 32-bit words long, and links them through a next-pointer field. It then loads the address of the first descriptor into the command pointer and credits the channel with a count of jobs. While the channel is enabled and credit remains, the sequencer reads the descriptor at the command pointer over a single 32-bit memory port. It checks the descriptor for consistency and, if the descriptor asks for a cipher operation, hands the operation to a transform unit through a request/done handshake. When the job is finished it writes a completion word back into the descriptor's status slot.

Two control bits in each descriptor decide what happens next: one takes a unit of credit away, the other says whether to follow the next pointer. If the next pointer is not followed, the channel drops its remaining credit and waits for software. A descriptor that fails a check stops the channel. The command pointer is left at the bad descriptor, an error code and a failure-point flag are latched, and an interrupt is raised whether or not the descriptor asked for one. The cipher datapath itself is outside this block. The testbench replaces it with a stub.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_req` and `xf_req` are low, and `pend_count`, `chan_status` and `cur_ptr` are zero.
- R2: No descriptor read is issued unless `chan_en` is high and `pend_count` is nonzero. A fetch reads the words at byte offsets 0,4,...,24 from `cur_ptr`, in that order, and holds `mem_addr` steady until `mem_ack`.
- R3: A pulse on `sema_wr` adds `sema_add` to `pend_count`, saturating at the all-ones value. A completed descriptor with control-1 bit 1 set removes one unit of credit.
- R4: A transform request is raised only for a descriptor with control-1 bit 5 set. It carries: encrypt from control-1 bit 8 (0 means decrypt), initial-chaining-value load from bit 9, hardware key from bit 10, and chained-block mode from control-2 bit 4. Source (word 3), destination (word 4), size (word 5) and payload pointer (word 6) pass through unchanged.
- R5: A descriptor that completes without error gets the value 1 written to its status word at byte offset 28.
- R6: When a completed descriptor has control-1 bit 2 set, `cur_ptr` is loaded from its next field (word 0) and the walk continues while credit remains. Without that bit, `cur_ptr` is unchanged and `pend_count` is cleared, unless a credit write arrives in the same cycle.
- R7: Control-1 bit 0 sets `irq` when its descriptor completes. `irq` stays high until `irq_ack` is pulsed.
- R8: A size whose low four bits are not zero halts the channel with `chan_status` = 0x0005_0002 (code 5 in bits 23:16, mismatch flag 0x02). It also raises `irq`, writes no status word and takes no credit.
- R9: Control-1 bit 2 set with a zero next field halts the channel with `chan_status` = 0x0001_0008.
- R10: With control-1 bit 5 set, key selection by bits 10 and 11 other than exactly one gives 0x0005_0004. A zero payload pointer when bit 11 or bit 9 is set gives 0x0004_0004. The checks take priority in this order: size, key selection, payload, next pointer.
- R11: A halted channel issues no memory or transform request, whatever credit arrives. A `ptr_wr` write loads `cur_ptr` (accepted only while not busy), clears `chan_status` and resumes the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| ptr_wr | input | 1 | Load command pointer |
| ptr_wdata | input | ADDR_W | New command pointer value |
| sema_wr | input | 1 | Add credit |
| sema_add | input | SEMA_W | Credit amount |
| irq_ack | input | 1 | Clears the interrupt |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| xf_req | output | 1 | Transform request, held until done |
| xf_encrypt | output | 1 | 1 encrypt, 0 decrypt |
| xf_cbc | output | 1 | Chained-block mode |
| xf_iv_load | output | 1 | Load initial chaining value from payload |
| xf_hw_key | output | 1 | Use the hardware key |
| xf_src | output | 32 | Source address |
| xf_dst | output | 32 | Destination address |
| xf_size | output | 32 | Byte count |
| xf_payload | output | 32 | Key/IV area address |
| xf_done | input | 1 | Transform finished |
| busy | output | 1 | Working, or about to start |
| cur_ptr | output | ADDR_W | Command pointer |
| pend_count | output | SEMA_W | Pending credit |
| chan_status | output | 32 | Error code (23:16) and failure flag (7:0) |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions check the following on every cycle: the memory address and direction stay steady while a request waits, the memory port and the transform port are never busy at once, every write-back writes 1 to the status slot of the current descriptor, a fetch starts only with enable and credit, a halt always brings the interrupt and a nonzero code, and a halted channel stays quiet. Credit can never be taken from an empty counter. Only the directed scenarios can show the rest: the transform fields decoded from each control bit, pointer following across a three-descriptor chain, stopping when credit runs out part way down a chain, credit dropped when a descriptor does not chain, saturation, each error code with its priority, and recovery by reloading the pointer.

// File: rtl/dcs_pkg.sv
// Shared definitions for the descriptor chain sequencer.
// Assumes 32-bit descriptor words, eight to a descriptor.
package dcs_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_XFORM, S_WB, S_DONE, S_HALT
    } seq_state_t;

    localparam int DESC_WORDS  = 8;
    localparam int FETCH_WORDS = DESC_WORDS - 1;

    // word slots inside a descriptor
    localparam int W_NEXT  = 0;
    localparam int W_CTRL1 = 1;
    localparam int W_CTRL2 = 2;
    localparam int W_SRC   = 3;
    localparam int W_DST   = 4;
    localparam int W_SIZE  = 5;
    localparam int W_PAYLD = 6;
    localparam int W_STAT  = 7;

    // control word 1 bit positions
    localparam int C1_IRQ    = 0;
    localparam int C1_DECR   = 1;
    localparam int C1_CHAIN  = 2;
    localparam int C1_CIPHER = 5;
    localparam int C1_ENC    = 8;
    localparam int C1_IVLD   = 9;
    localparam int C1_HWKEY  = 10;
    localparam int C1_PLKEY  = 11;
    // control word 2 bit positions
    localparam int C2_CBC    = 4;

    // error codes (status bits 23:16) and failure flags (bits 7:0)
    localparam logic [7:0] ERR_NONE      = 8'd0;
    localparam logic [7:0] ERR_NEXT_ZERO = 8'd1;
    localparam logic [7:0] ERR_PAYLOAD   = 8'd4;
    localparam logic [7:0] ERR_MODE      = 8'd5;
    localparam logic [7:0] FLG_PACKET    = 8'h08;
    localparam logic [7:0] FLG_SETUP     = 8'h04;
    localparam logic [7:0] FLG_MISMATCH  = 8'h02;

    localparam logic [31:0] STAT_DONE = 32'd1;
endpackage

// File: rtl/chan_sema.sv
// Pending-work credit counter for one channel.
// Adds software credit (saturating), removes one unit per consuming
// descriptor, and can be cleared. Assumes dec_en only when count > 0.
module chan_sema #(
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [SEMA_W-1:0] add_val,
    input  logic              dec_en,
    input  logic              clr_en,
    output logic [SEMA_W-1:0] cnt
);
    logic [SEMA_W-1:0] cnt_q;
    logic [SEMA_W:0]   base;
    logic [SEMA_W:0]   sum;

    // Next count: optional clear, plus credit, minus consumption.
    always_comb begin
        base = clr_en ? '0 : {1'b0, cnt_q};
        sum  = base
             + (add_en ? {1'b0, add_val} : '0)
             - ((dec_en && !clr_en) ? (SEMA_W+1)'(1) : '0);
    end

    // Count register with saturation at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= sum[SEMA_W] ? '1 : sum[SEMA_W-1:0];
    end

    assign cnt = cnt_q;

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> cnt_q != '0);
endmodule

// File: rtl/desc_check.sv
// Combinational consistency check of a fetched descriptor.
// Reports the highest-priority fault: size, key select, payload, next.
module desc_check #(
    parameter int BLK_BYTES = 16
) (
    input  logic                      cipher,
    input  logic                      chain,
    input  logic                      iv_load,
    input  logic                      hw_key,
    input  logic                      pl_key,
    input  logic [$clog2(BLK_BYTES)-1:0] size_low,
    input  logic                      next_zero,
    input  logic                      payload_zero,
    output logic                      bad,
    output logic [7:0]                code,
    output logic [7:0]                flags
);
    import dcs_pkg::*;

    // Priority-ordered fault selection.
    always_comb begin
        bad   = 1'b1;
        code  = ERR_NONE;
        flags = 8'h00;
        if (size_low != '0) begin
            code  = ERR_MODE;
            flags = FLG_MISMATCH;
        end else if (cipher && (hw_key == pl_key)) begin
            code  = ERR_MODE;
            flags = FLG_SETUP;
        end else if (cipher && (pl_key || iv_load) && payload_zero) begin
            code  = ERR_PAYLOAD;
            flags = FLG_SETUP;
        end else if (chain && next_zero) begin
            code  = ERR_NEXT_ZERO;
            flags = FLG_PACKET;
        end else begin
            bad = 1'b0;
        end
    end
endmodule

// File: rtl/desc_chain_seq.sv
// Single-channel descriptor chain sequencer.
// Fetches 7 descriptor words, checks them, runs the transform stub when
// asked, writes completion status, and follows the chain while credit
// remains. Assumes one outstanding memory access, acked per word.
module desc_chain_seq #(
    parameter int ADDR_W    = 32,
    parameter int SEMA_W    = 8,
    parameter int BLK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              ptr_wr,
    input  logic [ADDR_W-1:0] ptr_wdata,
    input  logic              sema_wr,
    input  logic [SEMA_W-1:0] sema_add,
    input  logic              irq_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              xf_req,
    output logic              xf_encrypt,
    output logic              xf_cbc,
    output logic              xf_iv_load,
    output logic              xf_hw_key,
    output logic [31:0]       xf_src,
    output logic [31:0]       xf_dst,
    output logic [31:0]       xf_size,
    output logic [31:0]       xf_payload,
    input  logic              xf_done,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic [SEMA_W-1:0] pend_count,
    output logic [31:0]       chan_status,
    output logic              irq
);
    import dcs_pkg::*;

    localparam int IDX_W   = $clog2(FETCH_WORDS);
    localparam int BLK_LSB = $clog2(BLK_BYTES);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [31:0]       status_q;
    logic              irq_q;
    logic [31:0]       desc_q [FETCH_WORDS];
    logic [SEMA_W-1:0] pend_cnt;

    logic              start_ok;
    logic              chk_bad;
    logic [7:0]        chk_code;
    logic [7:0]        chk_flags;
    logic [31:0]       ctrl1;
    logic [31:0]       ctrl2;
    logic              irq_set;
    logic              unused_bits;

    assign ctrl1    = desc_q[W_CTRL1];
    assign ctrl2    = desc_q[W_CTRL2];
    assign start_ok = chan_en && (pend_cnt != '0);

    // Descriptor word registers, one per fetched slot.
    for (genvar gi = 0; gi < FETCH_WORDS; gi++) begin : g_word
        // Capture slot gi when its read is acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)
                desc_q[gi] <= '0;
            else if (state_q == S_FETCH && mem_ack && idx_q == IDX_W'(gi))
                desc_q[gi] <= mem_rdata;
        end
    end

    desc_check #(.BLK_BYTES(BLK_BYTES)) u_check (
        .cipher       (ctrl1[C1_CIPHER]),
        .chain        (ctrl1[C1_CHAIN]),
        .iv_load      (ctrl1[C1_IVLD]),
        .hw_key       (ctrl1[C1_HWKEY]),
        .pl_key       (ctrl1[C1_PLKEY]),
        .size_low     (desc_q[W_SIZE][BLK_LSB-1:0]),
        .next_zero    (desc_q[W_NEXT] == 32'd0),
        .payload_zero (desc_q[W_PAYLD] == 32'd0),
        .bad          (chk_bad),
        .code         (chk_code),
        .flags        (chk_flags)
    );

    chan_sema #(.SEMA_W(SEMA_W)) u_sema (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (sema_wr),
        .add_val (sema_add),
        .dec_en  (state_q == S_DONE && ctrl1[C1_DECR]),
        .clr_en  (state_q == S_DONE && !ctrl1[C1_CHAIN]),
        .cnt     (pend_cnt)
    );

    // Sequencer state, word index, command pointer and error status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            ptr_q    <= '0;
            status_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (ptr_wr)
                        ptr_q <= ptr_wdata;
                    else if (start_ok) begin
                        state_q <= S_FETCH;
                        idx_q   <= '0;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        if (idx_q == IDX_W'(FETCH_WORDS - 1))
                            state_q <= S_CHECK;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                end
                S_CHECK: begin
                    if (chk_bad) begin
                        state_q  <= S_HALT;
                        status_q <= {8'h00, chk_code, 8'h00, chk_flags};
                    end else if (ctrl1[C1_CIPHER])
                        state_q <= S_XFORM;
                    else
                        state_q <= S_WB;
                end
                S_XFORM: if (xf_done) state_q <= S_WB;
                S_WB:    if (mem_ack) state_q <= S_DONE;
                S_DONE: begin
                    if (ctrl1[C1_CHAIN])
                        ptr_q <= desc_q[W_NEXT][ADDR_W-1:0];
                    state_q <= S_IDLE;
                end
                S_HALT: begin
                    if (ptr_wr) begin
                        ptr_q    <= ptr_wdata;
                        status_q <= '0;
                        state_q  <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign irq_set = (state_q == S_CHECK && chk_bad) ||
                     (state_q == S_DONE && ctrl1[C1_IRQ]);

    // Sticky interrupt; a new event wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (irq_set)
            irq_q <= 1'b1;
        else if (irq_ack)
            irq_q <= 1'b0;
    end

    // Memory port drive: descriptor reads, then status write-back.
    always_comb begin
        mem_req   = (state_q == S_FETCH) || (state_q == S_WB);
        mem_we    = (state_q == S_WB);
        mem_wdata = STAT_DONE;
        mem_addr  = ptr_q + ((state_q == S_WB) ? ADDR_W'(W_STAT * 4)
                                               : ADDR_W'({idx_q, 2'b00}));
    end

    // Transform handshake fields decoded from the held descriptor.
    always_comb begin
        xf_req     = (state_q == S_XFORM);
        xf_encrypt = ctrl1[C1_ENC];
        xf_cbc     = ctrl2[C2_CBC];
        xf_iv_load = ctrl1[C1_IVLD];
        xf_hw_key  = ctrl1[C1_HWKEY];
        xf_src     = desc_q[W_SRC];
        xf_dst     = desc_q[W_DST];
        xf_size    = desc_q[W_SIZE];
        xf_payload = desc_q[W_PAYLD];
    end

    assign busy        = (state_q != S_IDLE && state_q != S_HALT) ||
                         (state_q == S_IDLE && start_ok);
    assign cur_ptr     = ptr_q;
    assign pend_count  = pend_cnt;
    assign chan_status = status_q;
    assign irq         = irq_q;
    assign unused_bits = ^{ctrl1, ctrl2, desc_q[W_NEXT]};

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_fetch_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && $past(state_q) == S_IDLE) |->
            ($past(chan_en) && $past(pend_cnt) != '0));

    p_port_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && xf_req));

    p_xf_cipher_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xf_req |-> ctrl1[C1_CIPHER]);

    p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == 32'd1 &&
                                 mem_addr == ptr_q + ADDR_W'(W_STAT * 4)));

    p_halt_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_HALT) |-> (irq && status_q[23:16] != 8'd0));

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |-> (!mem_req && !xf_req));
endmodule

// File: tb/test_desc_chain_seq.sv
module test_desc_chain_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0, ptr_wr = 1'b0, sema_wr = 1'b0, irq_ack = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic [7:0]  sema_add = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xf_req, xf_encrypt, xf_cbc, xf_iv_load, xf_hw_key, xf_done;
    logic [31:0] xf_src, xf_dst, xf_size, xf_payload;
    logic        busy, irq;
    logic [31:0] cur_ptr, chan_status;
    logic [7:0]  pend_count;

    logic [31:0] mem [64];
    logic [31:0] rd_log [32];
    int          rd_n = 0;
    int          xf_n = 0;
    int          xcnt = 0;
    logic        cap_enc, cap_cbc, cap_iv, cap_hw;
    logic [31:0] cap_src, cap_size;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_chain_seq i_desc_chain_seq (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ptr_wr(ptr_wr),
        .ptr_wdata(ptr_wdata), .sema_wr(sema_wr), .sema_add(sema_add),
        .irq_ack(irq_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .xf_req(xf_req), .xf_encrypt(xf_encrypt),
        .xf_cbc(xf_cbc), .xf_iv_load(xf_iv_load), .xf_hw_key(xf_hw_key),
        .xf_src(xf_src), .xf_dst(xf_dst), .xf_size(xf_size),
        .xf_payload(xf_payload), .xf_done(xf_done), .busy(busy),
        .cur_ptr(cur_ptr), .pend_count(pend_count),
        .chan_status(chan_status), .irq(irq)
    );

    // memory model: ack one cycle after a request, alternating
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we)
                    mem[mem_addr[7:2]] <= mem_wdata;
                else begin
                    mem_rdata <= mem[mem_addr[7:2]];
                    rd_log[rd_n % 32] <= mem_addr;
                    rd_n <= rd_n + 1;
                end
            end
        end
    end

    // transform stub: done three cycles into a request, fields captured
    always @(posedge clk) begin
        if (!rst_n) begin
            xf_done <= 1'b0;
            xcnt <= 0;
        end else begin
            xf_done <= 1'b0;
            if (xf_req && !xf_done) begin
                if (xcnt == 2) begin
                    xf_done <= 1'b1;
                    xcnt <= 0;
                    xf_n <= xf_n + 1;
                    cap_enc <= xf_encrypt;  cap_cbc <= xf_cbc;
                    cap_iv <= xf_iv_load;   cap_hw <= xf_hw_key;
                    cap_src <= xf_src;      cap_size <= xf_size;
                end else
                    xcnt <= xcnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic put_desc(input int w, input logic [31:0] nxt, c1, c2,
                            src, dst, size, pl);
        mem[w] = nxt; mem[w+1] = c1; mem[w+2] = c2; mem[w+3] = src;
        mem[w+4] = dst; mem[w+5] = size; mem[w+6] = pl; mem[w+7] = '0;
    endtask

    task automatic set_ptr(input logic [31:0] p);
        @(negedge clk); ptr_wr = 1'b1; ptr_wdata = p;
        @(negedge clk); ptr_wr = 1'b0;
    endtask

    task automatic credit(input logic [7:0] n);
        @(negedge clk); sema_wr = 1'b1; sema_add = n;
        @(negedge clk); sema_wr = 1'b0;
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    // disable, reload pointer to 0 (clears a halt), enable
    task automatic restart();
        @(negedge clk); chan_en = 1'b0;
        set_ptr(32'h0);
        chan_en = 1'b1;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1", {31'd0, busy}, 0, "busy");
        chk("R1", {31'd0, irq}, 0, "irq");
        chk("R1", {31'd0, mem_req}, 0, "mem_req");
        chk("R1", {31'd0, xf_req}, 0, "xf_req");
        chk("R1", {24'd0, pend_count}, 0, "pend_count");
        chk("R1", chan_status, 0, "status");
        chk("R1", cur_ptr, 0, "cur_ptr");
    endtask

    task automatic t_single();
        int s;
        put_desc(0, 32'h0, 32'h523, 32'h10, 32'h1000, 32'h2000, 32'd32, 32'h80);
        set_ptr(32'h0);
        s = rd_n;
        credit(1);
        repeat (10) @(negedge clk);
        chk("R2", rd_n - s, 0, "reads while disabled");
        chk("R3", {24'd0, pend_count}, 1, "credit added");
        chan_en = 1'b1;
        wait_idle();
        chk("R2", rd_n - s, 7, "descriptor read count");
        for (int i = 0; i < 7; i++)
            chk("R2", rd_log[(s + i) % 32], 32'(i * 4), "fetch order");
        chk("R4", xf_n, 1, "transform count");
        chk("R4", {31'd0, cap_enc}, 1, "encrypt");
        chk("R4", {31'd0, cap_cbc}, 1, "cbc");
        chk("R4", {31'd0, cap_hw}, 1, "hw key");
        chk("R4", {31'd0, cap_iv}, 0, "iv load");
        chk("R4", cap_src, 32'h1000, "src");
        chk("R4", cap_size, 32'd32, "size");
        chk("R5", mem[7], 1, "status word");
        chk("R7", {31'd0, irq}, 1, "irq on completion");
        chk("R3", {24'd0, pend_count}, 0, "credit consumed");
        chk("R6", cur_ptr, 0, "no chain keeps pointer");
        ack_irq();
        chk("R7", {31'd0, irq}, 0, "irq acknowledged");
    endtask

    task automatic t_chain();
        int s, x;
        put_desc(8,  32'h40, 32'hA26, 32'h0, 32'h3000, 32'h4000, 32'd16, 32'h80);
        put_desc(16, 32'h60, 32'h006, 32'h0, 32'h0,    32'h0,    32'd48, 32'h0);
        put_desc(24, 32'h0,  32'h003, 32'h0, 32'h0,    32'h0,    32'd16, 32'h0);
        chan_en = 1'b0;
        set_ptr(32'h20);
        s = rd_n; x = xf_n;
        credit(3);
        chan_en = 1'b1;
        wait_idle();
        chk("R6", rd_n - s, 21, "three descriptors read");
        chk("R4", xf_n - x, 1, "only cipher descriptor transformed");
        chk("R4", {31'd0, cap_enc}, 0, "decrypt");
        chk("R4", {31'd0, cap_iv}, 1, "iv load");
        chk("R4", {31'd0, cap_cbc}, 0, "cbc off");
        chk("R4", {31'd0, cap_hw}, 0, "payload key");
        chk("R5", mem[15], 1, "stat A");
        chk("R5", mem[23], 1, "stat B");
        chk("R5", mem[31], 1, "stat C");
        chk("R6", cur_ptr, 32'h60, "pointer followed chain");
        chk("R3", {24'd0, pend_count}, 0, "three credits used");
        chk("R7", {31'd0, irq}, 1, "irq from last");
        ack_irq();
    endtask

    task automatic t_credit();
        put_desc(0, 32'h20, 32'h6, 32'h0, 0, 0, 32'd16, 0);
        put_desc(8, 32'h0,  32'h2, 32'h0, 0, 0, 32'd16, 0);
        chan_en = 1'b0;
        set_ptr(32'h0);
        credit(1);
        chan_en = 1'b1;
        wait_idle();
        chk("R6", cur_ptr, 32'h20, "stopped at next after credit ran out");
        chk("R3", {24'd0, pend_count}, 0, "credit empty");
        chk("R5", mem[7], 1, "first done");
        chk("R3", mem[15], 0, "second not run without credit");
        credit(1);
        wait_idle();
        chk("R3", mem[15], 1, "second run after credit");
        chk("R6", cur_ptr, 32'h20, "no chain keeps pointer");
    endtask

    task automatic t_clear();
        int s;
        put_desc(0, 32'h40, 32'h0, 32'h0, 0, 0, 32'd16, 0);
        chan_en = 1'b0;
        set_ptr(32'h0);
        s = rd_n;
        credit(2);
        chan_en = 1'b1;
        wait_idle();
        chk("R6", rd_n - s, 7, "ran once");
        chk("R6", {24'd0, pend_count}, 0, "credit dropped without chain");
        chk("R6", cur_ptr, 0, "pointer kept");
    endtask

    task automatic t_sat();
        chan_en = 1'b0;
        credit(200);
        credit(100);
        chk("R3", {24'd0, pend_count}, 255, "saturation");
        put_desc(0, 32'h0, 32'h0, 32'h0, 0, 0, 32'd16, 0);
        set_ptr(32'h0);
        chan_en = 1'b1;
        wait_idle();
        chk("R6", {24'd0, pend_count}, 0, "drained");
    endtask

    task automatic t_err_size();
        int s;
        put_desc(0, 32'h20, 32'h422, 32'h0, 0, 0, 32'd20, 32'h80);
        chan_en = 1'b0;
        set_ptr(32'h0);
        credit(1);
        chan_en = 1'b1;
        wait_idle();
        chk("R8", chan_status, 32'h0005_0002, "size error");
        chk("R8", {31'd0, irq}, 1, "irq on error");
        chk("R8", mem[7], 0, "no status write");
        chk("R8", {24'd0, pend_count}, 1, "credit kept");
        chk("R11", cur_ptr, 0, "pointer at failing descriptor");
        ack_irq();
        s = rd_n;
        credit(1);
        repeat (10) @(negedge clk);
        chk("R11", rd_n - s, 0, "halted, no fetch");
        chk("R11", chan_status, 32'h0005_0002, "status held");
        @(negedge clk); mem[5] = 32'd32;
        set_ptr(32'h0);
        wait_idle();
        chk("R11", chan_status, 0, "status cleared by pointer write");
        chk("R11", mem[7], 1, "resumed and completed");
        chk("R11", {24'd0, pend_count}, 0, "credit cleared");
    endtask

    task automatic t_errors();
        put_desc(0, 32'h0, 32'h4, 32'h0, 0, 0, 32'd16, 0);
        chan_en = 1'b0;
        set_ptr(32'h0);
        credit(1);
        chan_en = 1'b1;
        wait_idle();
        chk("R9", chan_status, 32'h0001_0008, "chain with zero next");
        chk("R9", {31'd0, irq}, 1, "irq");
        ack_irq();
        put_desc(0, 32'h0, 32'hC20, 32'h0, 0, 0, 32'd16, 32'h80);
        restart();
        chk("R10", chan_status, 32'h0005_0004, "both key selects");
        put_desc(0, 32'h0, 32'h020, 32'h0, 0, 0, 32'd16, 32'h80);
        restart();
        chk("R10", chan_status, 32'h0005_0004, "no key select");
        put_desc(0, 32'h0, 32'h820, 32'h0, 0, 0, 32'd16, 32'h0);
        restart();
        chk("R10", chan_status, 32'h0004_0004, "zero payload");
        put_desc(0, 32'h0, 32'h004, 32'h0, 0, 0, 32'd20, 32'h0);
        restart();
        chk("R10", chan_status, 32'h0005_0002, "size beats next check");
        chk("R8", mem[7], 0, "no status write on error");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_credit();
        t_clear();
        t_sat();
        t_err_size();
        t_errors();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule